// File: doc/BRIEF.md
# 4x4 Inverse Transform Reconstruction Unit

This block rebuilds one 4x4 tile of 10-bit pixels from a tile of signed residual coefficients and the matching tile of predicted pixels. It applies a separable integer inverse transform in two passes. The first pass works on each coefficient row. The intermediate matrix is then transposed, and the second pass works on the columns. A single rounding bias of 32 is injected between the passes. Each result is shifted down by six bits, saturated to 16 signed bits, added to its prediction pixel with signed saturation, and clipped to the pixel range 0..1023.

Both tiles enter together in one beat on a valid/ready input. The input is ready only while the unit is idle. Once a tile is taken, `in_ready` stays low until the tile has left and `done` has pulsed. The reconstruction leaves in two valid/ready beats of eight pixels each. A beat with `out_valid` high and `out_ready` low holds with its contents frozen, which is the only back-pressure the unit applies or obeys. All intermediate arithmetic is 32-bit signed.

Top module: `idct4_recon`

## Requirements
- R1: After reset `in_ready` is 1, and `out_valid` and `done` are 0.
- R2: A tile is taken on a cycle with `in_valid` and `in_ready` both high. From that edge until the cycle `done` is high, `in_ready` is 0 and any `in_valid` or data presented is ignored. Element (r,c) of `in_coef` sits at bits [(4r+c)*COEF_W +: COEF_W], and element (r,c) of `in_pred` at bits [(4r+c)*10 +: 10].
- R3: Both passes use the same butterfly, with arithmetic right shifts: e=a0+a2, f=a0-a2, g=(a1>>>1)-a3, h=a1+(a3>>>1), giving outputs (e+h, f+g, f-g, e-h). The first pass maps row r of coefficients to row r. The second pass maps column j of the intermediate matrix to column j of the result.
- R4: Before the column pass, 32 is added to each first-pass output of coefficient row 0. A lone DC coefficient of 31 therefore leaves the prediction unchanged, and a DC of 32 raises it by one.
- R5: Each column-pass result is shifted right arithmetically by 6 and saturated to the range -32768..32767.
- R6: The saturated value is added to the prediction with 16-bit signed saturation, and the sum is clipped to 0..1023.
- R7: Beat 0 (`out_pair`=0) carries rows 0 and 1, and beat 1 carries rows 2 and 3. Within a beat, slot s = 4*(row%2)+col sits at bits [s*10 +: 10].
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pair` and `out_pix` hold steady.
- R9: `out_valid` first rises three cycles after the accepting edge. `done` is a one-cycle pulse in the cycle after beat 1 is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coefficient and prediction tile offered |
| in_ready | output | 1 | Unit idle, tile can be taken |
| in_coef | input | 16*COEF_W | Signed residual coefficients |
| in_pred | input | 160 | Predicted pixels |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_pair | output | 1 | Beat index: 0 = rows 0/1, 1 = rows 2/3 |
| out_pix | output | 80 | Eight reconstructed pixels |
| done | output | 1 | Tile finished pulse |

## Verification
The row pass, the column pass and the reconstruction each take one register stage. Beat 0 is therefore due on the third negative edge after the edge where the bench saw `in_ready` with its own `in_valid`. The driver checks for `out_valid` low on the two negative edges before that one and high on it. The monitor compares every accepted beat in queue order against a bench-side arithmetic model. It expects `done` exactly one sampled cycle after a beat-1 handshake, and it checks that a stalled beat has not changed one sample later.

// File: rtl/idct4_pkg.sv
package idct4_pkg;
  localparam int DIM   = 4;
  localparam int CELLS = DIM * DIM;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_BEAT0,
    ST_BEAT1
  } idct4_state_e;
endpackage

// File: rtl/idct4_butterfly.sv
module idct4_butterfly #(
  parameter int W = 32
) (
  input  logic signed [W-1:0] a0,
  input  logic signed [W-1:0] a1,
  input  logic signed [W-1:0] a2,
  input  logic signed [W-1:0] a3,
  output logic signed [W-1:0] y0,
  output logic signed [W-1:0] y1,
  output logic signed [W-1:0] y2,
  output logic signed [W-1:0] y3
);
  logic signed [W-1:0] e, f, g, h;

  always_comb begin
    e  = a0 + a2;
    f  = a0 - a2;
    g  = (a1 >>> 1) - a3;
    h  = a1 + (a3 >>> 1);
    y0 = e + h;
    y1 = f + g;
    y2 = f - g;
    y3 = e - h;
  end
endmodule

// File: rtl/idct4_pixel.sv
module idct4_pixel #(
  parameter int W        = 32,
  parameter int PIX_W    = 10,
  parameter int NARROW_W = 16,
  parameter int SHIFT    = 6
) (
  input  logic signed [W-1:0] val,
  input  logic [PIX_W-1:0]    pred,
  output logic [PIX_W-1:0]    pix
);
  localparam int NMAX = (1 << (NARROW_W - 1)) - 1;
  localparam int NMIN = -(1 << (NARROW_W - 1));
  localparam int PMAX = (1 << PIX_W) - 1;
  localparam logic signed [W-1:0]        HI_W   = W'(NMAX);
  localparam logic signed [W-1:0]        LO_W   = W'(NMIN);
  localparam logic signed [NARROW_W:0]   HI_X   = (NARROW_W + 1)'(NMAX);
  localparam logic signed [NARROW_W:0]   LO_X   = (NARROW_W + 1)'(NMIN);
  localparam logic signed [NARROW_W-1:0] PMAX_N = NARROW_W'(PMAX);

  logic signed [W-1:0]        shifted;
  logic signed [NARROW_W-1:0] narrow;
  logic signed [NARROW_W:0]   wide;
  logic signed [NARROW_W-1:0] sum;

  always_comb begin
    shifted = val >>> SHIFT;
    if (shifted > HI_W)      narrow = NARROW_W'(NMAX);
    else if (shifted < LO_W) narrow = NARROW_W'(NMIN);
    else                     narrow = shifted[NARROW_W-1:0];

    wide = {narrow[NARROW_W-1], narrow}
         + $signed({{(NARROW_W + 1 - PIX_W){1'b0}}, pred});
    if (wide > HI_X)      sum = NARROW_W'(NMAX);
    else if (wide < LO_X) sum = NARROW_W'(NMIN);
    else                  sum = wide[NARROW_W-1:0];

    if (sum < 0)           pix = '0;
    else if (sum > PMAX_N) pix = PIX_W'(PMAX);
    else                   pix = sum[PIX_W-1:0];
  end

  always_comb begin
    if (pred == '0 && val < 0)
      AST_NEG_ON_ZERO_PRED: assert (pix == '0); // R6
    if (val >= 0 && val < W'(1 << SHIFT))
      AST_SMALL_KEEPS_PRED: assert (pix == pred); // R5
  end
endmodule

// File: rtl/idct4_ctrl.sv
module idct4_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic load_in,
  output logic load_mid,
  output logic load_res,
  output logic out_valid,
  output logic out_pair,
  output logic done
);
  import idct4_pkg::*;

  idct4_state_e state_q, state_d;
  logic         done_q;

  always_comb begin
    in_ready  = (state_q == ST_IDLE);
    load_in   = in_ready && in_valid;
    load_mid  = (state_q == ST_ROW);
    load_res  = (state_q == ST_COL);
    out_valid = (state_q == ST_BEAT0) || (state_q == ST_BEAT1);
    out_pair  = (state_q == ST_BEAT1);
    done      = done_q;
    state_d   = state_q;
    unique case (state_q)
      ST_IDLE:  if (in_valid)  state_d = ST_ROW;
      ST_ROW:                  state_d = ST_COL;
      ST_COL:                  state_d = ST_BEAT0;
      ST_BEAT0: if (out_ready) state_d = ST_BEAT1;
      ST_BEAT1: if (out_ready) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_BEAT1) && out_ready;
    end
  end

  AST_BUSY_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

// File: rtl/idct4_recon.sv
module idct4_recon #(
  parameter int COEF_W   = 20,
  parameter int INT_W    = 32,
  parameter int PIX_W    = 10,
  parameter int NARROW_W = 16,
  parameter int SHIFT    = 6,
  parameter int BIAS     = 32
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    in_valid,
  output logic                                    in_ready,
  input  logic [idct4_pkg::CELLS*COEF_W-1:0]      in_coef,
  input  logic [idct4_pkg::CELLS*PIX_W-1:0]       in_pred,
  output logic                                    out_valid,
  input  logic                                    out_ready,
  output logic                                    out_pair,
  output logic [(idct4_pkg::CELLS/2)*PIX_W-1:0]   out_pix,
  output logic                                    done
);
  import idct4_pkg::*;

  localparam int BEAT = CELLS / 2;
  localparam logic signed [INT_W-1:0] BIAS_V = INT_W'(BIAS);

  logic load_in, load_mid, load_res;

  logic signed [INT_W-1:0] coef_ext [CELLS];
  logic signed [INT_W-1:0] coef_q   [CELLS];
  logic [PIX_W-1:0]        pred_q   [CELLS];
  logic signed [INT_W-1:0] row_y    [CELLS];
  logic signed [INT_W-1:0] mid_q    [CELLS];
  logic signed [INT_W-1:0] col_y    [CELLS];
  logic [PIX_W-1:0]        pix_d    [CELLS];
  logic [PIX_W-1:0]        res_q    [CELLS];

  idct4_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .load_in  (load_in),
    .load_mid (load_mid),
    .load_res (load_res),
    .out_valid(out_valid),
    .out_pair (out_pair),
    .done     (done)
  );

  for (genvar i = 0; i < CELLS; i++) begin : g_ext
    assign coef_ext[i] = {{(INT_W - COEF_W){in_coef[i*COEF_W + COEF_W - 1]}},
                          in_coef[i*COEF_W +: COEF_W]};
  end

  // first pass: one butterfly per coefficient row
  for (genvar r = 0; r < DIM; r++) begin : g_row
    idct4_butterfly #(.W(INT_W)) u_bf (
      .a0(coef_q[r*DIM + 0]), .a1(coef_q[r*DIM + 1]),
      .a2(coef_q[r*DIM + 2]), .a3(coef_q[r*DIM + 3]),
      .y0(row_y[r*DIM + 0]),  .y1(row_y[r*DIM + 1]),
      .y2(row_y[r*DIM + 2]),  .y3(row_y[r*DIM + 3])
    );
  end

  // second pass: mid_q is stored transposed, vector j = column j
  for (genvar j = 0; j < DIM; j++) begin : g_col
    idct4_butterfly #(.W(INT_W)) u_bf (
      .a0(mid_q[j*DIM + 0]), .a1(mid_q[j*DIM + 1]),
      .a2(mid_q[j*DIM + 2]), .a3(mid_q[j*DIM + 3]),
      .y0(col_y[0*DIM + j]), .y1(col_y[1*DIM + j]),
      .y2(col_y[2*DIM + j]), .y3(col_y[3*DIM + j])
    );
  end

  for (genvar i = 0; i < CELLS; i++) begin : g_pix
    idct4_pixel #(
      .W(INT_W), .PIX_W(PIX_W), .NARROW_W(NARROW_W), .SHIFT(SHIFT)
    ) u_pix (
      .val (col_y[i]),
      .pred(pred_q[i]),
      .pix (pix_d[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) begin
        coef_q[i] <= '0;
        pred_q[i] <= '0;
        mid_q[i]  <= '0;
        res_q[i]  <= '0;
      end
    end else begin
      if (load_in) begin
        for (int i = 0; i < CELLS; i++) begin
          coef_q[i] <= coef_ext[i];
          pred_q[i] <= in_pred[i*PIX_W +: PIX_W];
        end
      end
      if (load_mid) begin
        for (int j = 0; j < DIM; j++) begin
          for (int r = 0; r < DIM; r++) begin
            mid_q[j*DIM + r] <= row_y[r*DIM + j] + ((r == 0) ? BIAS_V : '0);
          end
        end
      end
      if (load_res) begin
        for (int i = 0; i < CELLS; i++) res_q[i] <= pix_d[i];
      end
    end
  end

  always_comb begin
    for (int s = 0; s < BEAT; s++) begin
      out_pix[s*PIX_W +: PIX_W] = res_q[(out_pair ? BEAT : 0) + s];
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_pair))); // R8
  AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_pair) |=> (out_valid && out_pair)); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready && out_pair)); // R9
  AST_TAKE_THEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !out_valid)); // R2
endmodule

// File: tb/test_idct4_recon.sv
module test_idct4_recon;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 20;

  typedef struct {
    logic        pair;
    logic [79:0] pix;
    string       tag;
  } beat_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [16*CW-1:0]  in_coef = '0;
  logic [159:0]      in_pred = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic              out_pair;
  logic [79:0]       out_pix;
  logic              done;

  int    checks = 0;
  int    errors = 0;
  bit    stall_mode = 1'b0;
  beat_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  idct4_recon #(.COEF_W(CW)) i_idct4_recon (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_pred(in_pred), .out_valid(out_valid),
    .out_ready(out_ready), .out_pair(out_pair), .out_pix(out_pix), .done(done)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  function automatic void bfly(input longint a0, a1, a2, a3,
                               output longint y0, y1, y2, y3);
    longint e, f, g, h;
    e = a0 + a2; f = a0 - a2;
    g = (a1 >>> 1) - a3; h = a1 + (a3 >>> 1);
    y0 = e + h; y1 = f + g; y2 = f - g; y3 = e - h;
  endfunction

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic logic [159:0] model(input logic [16*CW-1:0] c, input logic [159:0] p);
    longint t[16];
    longint y[4];
    logic [159:0] o;
    for (int r = 0; r < 4; r++) begin
      bfly(longint'($signed(c[(r*4+0)*CW +: CW])), longint'($signed(c[(r*4+1)*CW +: CW])),
           longint'($signed(c[(r*4+2)*CW +: CW])), longint'($signed(c[(r*4+3)*CW +: CW])),
           y[0], y[1], y[2], y[3]);
      for (int k = 0; k < 4; k++) t[r*4+k] = y[k];
    end
    for (int j = 0; j < 4; j++) begin
      bfly(t[j] + 32, t[4+j], t[8+j], t[12+j], y[0], y[1], y[2], y[3]);
      for (int i = 0; i < 4; i++) begin
        longint v;
        v = sat16(y[i] >>> 6);
        v = sat16(v + longint'(p[(i*4+j)*10 +: 10]));
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        o[(i*4+j)*10 +: 10] = 10'(v);
      end
    end
    return o;
  endfunction

  task automatic send(input logic [16*CW-1:0] c, input logic [159:0] p,
                      input bit junk, input string tag);
    logic [159:0] e;
    beat_t b;
    e = model(c, p);
    b.pair = 1'b0; b.pix = e[79:0];   b.tag = tag; exp_q.push_back(b);
    b.pair = 1'b1; b.pix = e[159:80]; b.tag = tag; exp_q.push_back(b);
    @(posedge clk); #1;
    in_valid = 1'b1; in_coef = c; in_pred = p;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    if (junk) begin in_coef = ~c; in_pred = ~p; end
    else in_valid = 1'b0;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk(out_valid == (n == 2), "R9 latency out_valid", out_valid, n == 2);
      if (junk) chk(!in_ready, "R2 in_ready while busy", in_ready, 0);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    bit          prev_last = 1'b0;
    bit          prev_stall = 1'b0;
    logic [79:0] stall_pix = '0;
    logic        stall_pair = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall) begin
          chk(out_valid && out_pix == stall_pix && out_pair == stall_pair,
              "R8 stalled beat changed", longint'(out_pix[31:0]), longint'(stall_pix[31:0]));
        end
        if (done || prev_last) chk(done == prev_last, "R9 done pulse", done, prev_last);
        prev_last = 1'b0;
        prev_stall = out_valid && !out_ready;
        stall_pix = out_pix; stall_pair = out_pair;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected beat", out_pair, -1);
          end else begin
            beat_t b;
            b = exp_q.pop_front();
            chk(out_pair == b.pair, {b.tag, " R7 beat order"}, out_pair, b.pair);
            for (int s = 0; s < 8; s++) begin
              chk(out_pix[s*10 +: 10] == b.pix[s*10 +: 10],
                  $sformatf("%s pixel row %0d col %0d", b.tag, 2*b.pair + s/4, s%4),
                  out_pix[s*10 +: 10], b.pix[s*10 +: 10]);
            end
          end
          prev_last = out_pair;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [16*CW-1:0] one_coef(input int idx, input int v);
    logic [16*CW-1:0] c = '0;
    c[idx*CW +: CW] = CW'(v);
    return c;
  endfunction

  function automatic logic [159:0] flat_pred(input int v);
    logic [159:0] p;
    for (int i = 0; i < 16; i++) p[i*10 +: 10] = 10'(v);
    return p;
  endfunction

  initial begin
    logic [16*CW-1:0] c;
    logic [159:0]     p;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);

    // zero residual: prediction passes through (R7 layout by ramp)
    for (int i = 0; i < 16; i++) p[i*10 +: 10] = 10'(i*60 + 7);
    send('0, p, 1'b0, "R7 ramp");
    // rounding bias boundary
    send(one_coef(0, 31), flat_pred(500), 1'b0, "R4 dc31");
    send(one_coef(0, 32), flat_pred(500), 1'b0, "R4 dc32");
    // large negative clipped at zero
    send(one_coef(0, -64*600), flat_pred(100), 1'b0, "R6 low clip");
    send(one_coef(0, 64*2000), flat_pred(900), 1'b0, "R6 high clip");
    // all coefficients at maximum: 16-bit saturation
    for (int i = 0; i < 16; i++) c[i*CW +: CW] = CW'((1 << (CW-1)) - 1);
    send(c, flat_pred(200), 1'b0, "R5 saturate");
    for (int i = 0; i < 16; i++) c[i*CW +: CW] = CW'(-(1 << (CW-1)));
    send(c, flat_pred(800), 1'b0, "R5 saturate neg");
    // odd and negative values through the half-weight taps
    c = '0;
    c[1*CW +: CW] = CW'(-3); c[3*CW +: CW] = CW'(5); c[5*CW +: CW] = CW'(-7);
    c[11*CW +: CW] = CW'(-1); c[13*CW +: CW] = CW'(301); c[15*CW +: CW] = CW'(-257);
    send(c, flat_pred(512), 1'b0, "R3 odd taps");
    // input held with other data while busy
    for (int i = 0; i < 16; i++) begin
      c[i*CW +: CW] = CW'($urandom % 4001) - CW'(2000);
      p[i*10 +: 10] = 10'($urandom % 1024);
    end
    send(c, p, 1'b1, "R2 busy ignore");
    // back-pressure on the output
    stall_mode = 1'b1;
    for (int n = 0; n < 8; n++) begin
      for (int i = 0; i < 16; i++) begin
        c[i*CW +: CW] = CW'($urandom % 20001) - CW'(10000);
        p[i*10 +: 10] = 10'($urandom % 1024);
      end
      send(c, p, 1'b0, "R8 random");
    end
    while (exp_q.size() != 0) @(negedge clk);
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R2 idle again", in_ready, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule